// File: doc/BRIEF.md
# Coincident-Select Reconfigurable Lookup Table

This block is a lookup table whose contents are a square grid of one-bit configuration cells, SIDE cells on each side (SIDE = 8 by default, so 64 bits). The stored bit pattern is the truth table of a logic function of 2·log2(SIDE) inputs. The function can be reprogrammed at any time through a narrow configuration port. That port carries a binary row address, a binary column address, a set strobe and a clear pulse. It does not carry one wire per row and per column.

Two binary decoders turn the addresses into one-hot row and column select lines. These lines are active only during a set write. A cell turns to 1 only where its row line and its column line are asserted together. A cell whose row or column alone is selected keeps its value. A write never turns a 1 back into a 0: the only way to clear cells is the clear pulse, which empties the whole grid in one cycle.

To load a function, software pulses the clear, then issues one set write for each 1 in the truth table, in any order. In evaluate cycles the lookup input picks one cell, and that cell appears on the registered output one clock later.

Top module: `cslut_top`

## Requirements
- R1: While `rst_n` is low, every cell and `lkp_out` are 0.
- R2: A cycle with `set_stb` high and `clr_all` low sets the cell at row `row_addr`, column `col_addr` to 1.
- R3: That set write leaves unchanged every other cell, including cells that share only its row or only its column.
- R4: A set write never changes a 1 into a 0, including a repeat write to a cell that is already 1.
- R5: A cycle with `clr_all` high clears all SIDE×SIDE cells to 0 by the next clock.
- R6: When `clr_all` and `set_stb` are high in the same cycle, the clear wins and no cell is left at 1.
- R7: In an evaluate cycle (both `set_stb` and `clr_all` low), `lkp_out` takes, at the next clock edge, the cell at row `lkp_in[2·AW-1:AW]` and column `lkp_in[AW-1:0]`, where AW = log2(SIDE). The cell index is row·SIDE + column.
- R8: While `set_stb` or `clr_all` is high, `lkp_out` keeps its previous value.
- R9: Each set write turns on exactly one row line and exactly one column line. With no write in progress, no select line is active, so exactly one cell can change per write.
- R10: After a clear followed by set writes in any order, the table equals the written set of 1 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_all | input | 1 | Clear pulse: empties the whole grid |
| set_stb | input | 1 | Set strobe: writes a 1 at the addressed cell |
| row_addr | input | log2(SIDE) | Binary row address for a set write |
| col_addr | input | log2(SIDE) | Binary column address for a set write |
| lkp_in | input | 2·log2(SIDE) | Lookup index: row in the upper half, column in the lower half |
| lkp_out | output | 1 | Registered table output |

## Verification
The bench sets two cells that lie on crossing rows and columns, then checks that the two crossing cells they do not address stay as they were. A design that wrote on a half-selected line would show a 1 there. It repeats a write to a cell that is already set and fires the clear and the set strobe together. A write that toggles or overwrites would lose the 1, and a design with the wrong priority would leave a stray 1 after the clear. It also swaps the row and column halves of the lookup index to catch a transposed read. It changes the lookup input while a write or clear is in progress and checks that the output neither updates nor follows the change.

// File: rtl/cslut_pkg.sv
package cslut_pkg;

  typedef enum logic [1:0] {
    OP_EVAL  = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2
  } cslut_op_e;

  // The clear outranks the set strobe; evaluation only when both are idle.
  function automatic cslut_op_e cslut_classify(input logic set_i, input logic clr_i);
    if (clr_i)      return OP_CLEAR;
    else if (set_i) return OP_SET;
    else            return OP_EVAL;
  endfunction

endpackage

// File: rtl/cslut_decoder.sv
module cslut_decoder #(
  parameter int AW = 3,
  localparam int LINES = 1 << AW
) (
  input  logic             en_i,
  input  logic [AW-1:0]    addr_i,
  output logic [LINES-1:0] sel_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign sel_o[g] = en_i && (addr_i == AW'(g));
  end

endmodule

// File: rtl/cslut_cell_array.sv
module cslut_cell_array #(
  parameter int SIDE = 8,
  localparam int CELLS = SIDE * SIDE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [SIDE-1:0]  row_sel_i,
  input  logic [SIDE-1:0]  col_sel_i,
  output logic [CELLS-1:0] cells_o
);

  logic [CELLS-1:0] cells_q;
  logic [CELLS-1:0] cells_nxt;
  logic [CELLS-1:0] hit;
  logic             upd_en;

  for (genvar r = 0; r < SIDE; r++) begin : g_row
    for (genvar c = 0; c < SIDE; c++) begin : g_col
      // A cell is hit only when both of its lines coincide.
      assign hit[r*SIDE + c] = row_sel_i[r] & col_sel_i[c];
    end
  end

  assign upd_en = clr_i | (|row_sel_i);

  always_comb begin
    if (clr_i) cells_nxt = '0;
    else       cells_nxt = cells_q | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cells_q <= '0;
    else if (upd_en) cells_q <= cells_nxt;
  end

  assign cells_o = cells_q;

endmodule

// File: rtl/cslut_read_mux.sv
module cslut_read_mux #(
  parameter int SIDE = 8,
  localparam int AW    = $clog2(SIDE),
  localparam int IW    = 2 * AW,
  localparam int CELLS = SIDE * SIDE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_i,
  input  logic [CELLS-1:0] cells_i,
  input  logic [IW-1:0]    idx_i,
  output logic             bit_o
);

  logic [AW-1:0] row_idx;
  logic [AW-1:0] col_idx;
  logic [SIDE-1:0] row_bits;
  logic          bit_nxt;
  logic          bit_q;

  assign row_idx = idx_i[IW-1:AW];
  assign col_idx = idx_i[AW-1:0];

  // First pick the row, then the column inside it.
  always_comb begin
    row_bits = '0;
    for (int c = 0; c < SIDE; c++) begin
      row_bits[c] = cells_i[int'(row_idx) * SIDE + c];
    end
    bit_nxt = row_bits[col_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bit_q <= 1'b0;
    else if (eval_i) bit_q <= bit_nxt;
  end

  assign bit_o = bit_q;

endmodule

// File: rtl/cslut_top.sv
module cslut_top #(
  parameter int SIDE = 8,
  localparam int AW    = $clog2(SIDE),
  localparam int IW    = 2 * AW,
  localparam int CELLS = SIDE * SIDE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic          set_stb,
  input  logic [AW-1:0] row_addr,
  input  logic [AW-1:0] col_addr,
  input  logic [IW-1:0] lkp_in,
  output logic          lkp_out
);
  import cslut_pkg::*;

  cslut_op_e        op;
  logic             wr_en;
  logic             clr_en;
  logic             eval_en;
  logic [SIDE-1:0]  row_sel;
  logic [SIDE-1:0]  col_sel;
  logic [CELLS-1:0] cells;

  assign op      = cslut_classify(set_stb, clr_all);
  assign wr_en   = (op == OP_SET);
  assign clr_en  = (op == OP_CLEAR);
  assign eval_en = (op == OP_EVAL);

  cslut_decoder #(.AW(AW)) u_row_dec (
    .en_i   (wr_en),
    .addr_i (row_addr),
    .sel_o  (row_sel)
  );

  cslut_decoder #(.AW(AW)) u_col_dec (
    .en_i   (wr_en),
    .addr_i (col_addr),
    .sel_o  (col_sel)
  );

  cslut_cell_array #(.SIDE(SIDE)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_en),
    .row_sel_i (row_sel),
    .col_sel_i (col_sel),
    .cells_o   (cells)
  );

  cslut_read_mux #(.SIDE(SIDE)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .eval_i  (eval_en),
    .cells_i (cells),
    .idx_i   (lkp_in),
    .bit_o   (lkp_out)
  );

endmodule

// File: rtl/cslut_checker.sv
module cslut_checker #(
  parameter int SIDE = 8,
  localparam int AW    = $clog2(SIDE),
  localparam int IW    = 2 * AW,
  localparam int CELLS = SIDE * SIDE
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_all,
  input logic             set_stb,
  input logic [IW-1:0]    lkp_in,
  input logic             lkp_out,
  input logic [SIDE-1:0]  row_sel,
  input logic [SIDE-1:0]  col_sel,
  input logic [CELLS-1:0] cells
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_empty_R1: assert (cells == '0 && lkp_out == 1'b0)
        else $error("R1: state not cleared in reset");
    end
  end

  assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && !clr_all) |-> ($countones(row_sel) == 1 && $countones(col_sel) == 1))
    else $error("R9: select lines not one-hot during write");

  assert_sel_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_stb && !clr_all) |-> (row_sel == '0 && col_sel == '0))
    else $error("R9: select line active with no write");

  assert_one_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && !clr_all) |=> ($countones(cells ^ $past(cells)) <= 1))
    else $error("R3: write changed more than one cell");

  assert_never_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all |=> ((cells & $past(cells)) == $past(cells)))
    else $error("R4: a 1 was lost without a clear");

  assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (cells == '0))
    else $error("R5/R6: grid not empty after clear");

  assert_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_all) |=> (lkp_out == $past(cells[lkp_in])))
    else $error("R7: output does not match addressed cell");

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb || clr_all) |=> $stable(lkp_out))
    else $error("R8: output moved during configuration");

endmodule

bind cslut_top cslut_checker #(.SIDE(SIDE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clr_all (clr_all),
  .set_stb (set_stb),
  .lkp_in  (lkp_in),
  .lkp_out (lkp_out),
  .row_sel (row_sel),
  .col_sel (col_sel),
  .cells   (cells)
);

// File: tb/cslut_top_bench.sv
`timescale 1ns/1ps
module cslut_top_bench;
  localparam int SIDE = 8;
  localparam int AW   = $clog2(SIDE);
  localparam int IW   = 2 * AW;
  localparam int N    = SIDE * SIDE;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr_all;
  logic          set_stb;
  logic [AW-1:0] row_addr;
  logic [AW-1:0] col_addr;
  logic [IW-1:0] lkp_in;
  logic          lkp_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [N-1:0] model;

  always #4 clk = ~clk;

  cslut_top #(.SIDE(SIDE)) u_cslut_top (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .set_stb(set_stb),
    .row_addr(row_addr), .col_addr(col_addr), .lkp_in(lkp_in), .lkp_out(lkp_out)
  );

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic lookup(input int idx, output logic val);
    @(negedge clk);
    lkp_in = IW'(idx);
    @(negedge clk);
    val = lkp_out;
  endtask

  task automatic scan(output logic [N-1:0] tbl);
    for (int i = 0; i < N; i++) begin
      logic v;
      lookup(i, v);
      tbl[i] = v;
    end
  endtask

  task automatic write_one(input int r, input int c);
    @(negedge clk);
    row_addr = AW'(r); col_addr = AW'(c); set_stb = 1'b1;
    @(negedge clk);
    set_stb = 1'b0;
    model[r*SIDE + c] = 1'b1;
  endtask

  task automatic clear_grid();
    @(negedge clk);
    clr_all = 1'b1;
    @(negedge clk);
    clr_all = 1'b0;
    model = '0;
  endtask

  task automatic t_reset();
    logic [N-1:0] tbl;
    rst_n = 1'b0; clr_all = 0; set_stb = 0; row_addr = 0; col_addr = 0; lkp_in = 0;
    model = '0;
    repeat (3) @(negedge clk);
    check_bit("R1 output in reset", lkp_out, 1'b0);
    rst_n = 1'b1;
    scan(tbl);
    check_vec("R1 grid empty after reset", tbl, '0);
  endtask

  task automatic t_single_set();
    logic [N-1:0] tbl;
    write_one(5, 2);
    scan(tbl);
    check_vec("R2 single cell set", tbl, model);
    check_bit("R9 exactly one cell set", ($countones(tbl) == 1), 1'b1);
  endtask

  task automatic t_half_select();
    logic v;
    write_one(5, 6);
    write_one(3, 2);
    lookup(3*SIDE + 6, v);
    check_bit("R3 half-selected cell (3,6) untouched", v, 1'b0);
    lookup(5*SIDE + 2, v);
    check_bit("R3 half-selected cell (5,2) keeps 1", v, 1'b1);
    lookup(5*SIDE + 5, v);
    check_bit("R3 row-only cell (5,5) untouched", v, 1'b0);
  endtask

  task automatic t_no_clear();
    logic [N-1:0] tbl;
    write_one(5, 2);
    scan(tbl);
    check_vec("R4 repeat write keeps all ones", tbl, model);
  endtask

  task automatic t_hold();
    logic v;
    lookup(5*SIDE + 2, v);
    check_bit("R8 precondition read", v, 1'b1);
    @(negedge clk);
    lkp_in = IW'(7*SIDE + 7); row_addr = 0; col_addr = 0; set_stb = 1'b1;
    model[0] = 1'b1;
    @(negedge clk);
    check_bit("R8 hold during set", lkp_out, 1'b1);
    set_stb = 1'b0; clr_all = 1'b1;
    @(negedge clk);
    check_bit("R8 hold during clear", lkp_out, 1'b1);
    clr_all = 1'b0;
    model = '0;
  endtask

  task automatic t_clear();
    logic [N-1:0] tbl;
    write_one(1, 1);
    write_one(7, 0);
    clear_grid();
    scan(tbl);
    check_vec("R5 clear empties grid", tbl, '0);
  endtask

  task automatic t_priority();
    logic [N-1:0] tbl;
    write_one(2, 4);
    @(negedge clk);
    row_addr = 3; col_addr = 3; set_stb = 1'b1; clr_all = 1'b1;
    @(negedge clk);
    set_stb = 1'b0; clr_all = 1'b0;
    model = '0;
    scan(tbl);
    check_vec("R6 clear beats set", tbl, '0);
  endtask

  task automatic t_index_split();
    logic v;
    write_one(1, 6);
    @(negedge clk);
    lkp_in = IW'(1*SIDE + 6);
    #1;
    check_bit("R7 no change before clock edge", lkp_out, 1'b0);
    @(negedge clk);
    check_bit("R7 row upper, column lower", lkp_out, 1'b1);
    lookup(6*SIDE + 1, v);
    check_bit("R7 transposed index reads 0", v, 1'b0);
    clear_grid();
  endtask

  task automatic t_program();
    logic [N-1:0] tbl;
    logic [N-1:0] want;
    for (int i = 0; i < N; i++) want[i] = ((i * 37 + 11) % 5) < 2;
    clear_grid();
    for (int i = N - 1; i >= 0; i--) begin
      int k = (i * 23) % N;
      if (want[k]) write_one(k / SIDE, k % SIDE);
    end
    scan(tbl);
    check_vec("R10 programmed function", tbl, want);
    check_vec("R10 model agrees", model, want);
  endtask

  initial begin
    t_reset();
    t_single_set();
    t_half_select();
    t_no_clear();
    t_hold();
    t_clear();
    t_priority();
    t_index_split();
    t_program();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule